// File: doc/BRIEF.md
# Effective Address Generation Unit

This block forms the memory addresses that a 16-bit load/store datapath uses for both operands of a move. It holds the bank of working registers. For each operation it takes a decoded addressing mode, a register selector and an instruction field for the source and for the destination. It also takes one index-register selector that the two operands share. From these it produces two effective addresses, a flag for each operand that tells whether a memory address was formed, and the pointer write-backs that the modifying modes cause.

Pointer write-backs update the internal bank at the same clock edge that registers the outputs. The next operation therefore sees the modified pointers without a stall. A separate write port lets the result path load any register. Each operand may use its own mode. When both operands modify the same register in one operation, the destination's update wins. A pointer update also wins over a write-port update to the same register in the same cycle.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset all working registers read as 0x0000, `valid_o` is 0, both addresses are 0 and no write-back is flagged.
- R2: Mode code 0 (file-register direct) gives an address equal to the instruction field zero-extended to 16 bits, with the memory flag set and no write-back.
- R3: Mode code 1 (register direct) and the unused code 7 form no address: the memory flag is 0, the address is 0, there is no write-back and the register keeps its value.
- R4: Mode code 2 (indirect) gives an address equal to the selected register, with no write-back.
- R5: Mode code 3 (post-modified) gives the register's current value as the address. The register is then written with that value plus the step. The step is 1 when the byte flag is 1 and 2 when it is 0, and it is negated when the decrement flag is 1.
- R6: Mode code 4 (pre-modified) adds the same signed step first. The adjusted value is both the address and the write-back value.
- R7: Mode code 5 (indexed) gives the selected register plus the register named by the one shared index selector. Both operands read that same index register.
- R8: Mode code 6 (literal offset) gives the selected register plus the instruction field sign-extended from its top bit.
- R9: All address and pointer arithmetic wraps modulo 2^16.
- R10: Both operands of an operation read register values as they stood before that operation. The operation's write-backs are visible to the next one.
- R11: When source and destination both modify the same register, only the destination's value is stored and the source write-back flag is 0.
- R12: The register write port updates the selected register at the clock edge. A pointer write-back to the same register in the same cycle takes priority over it.
- R13: Results appear one clock after `op_valid_i`, with `valid_o` set. A cycle without `op_valid_i` gives `valid_o` 0 and no write-back, and both addresses and memory flags hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write port enable |
| wr_sel_i | input | RSEL_W | Register written by the write port |
| wr_data_i | input | DATA_W | Write port data |
| op_valid_i | input | 1 | An operation is presented this cycle |
| idx_sel_i | input | RSEL_W | Shared index-register selector |
| src_mode_i | input | 3 | Source addressing mode code |
| src_sel_i | input | RSEL_W | Source base register |
| src_field_i | input | FIELD_W | Source file address or literal offset |
| src_dec_i | input | 1 | Source pointer moves down |
| src_byte_i | input | 1 | Source is a byte access (step 1) |
| dst_mode_i | input | 3 | Destination addressing mode code |
| dst_sel_i | input | RSEL_W | Destination base register |
| dst_field_i | input | FIELD_W | Destination file address or literal offset |
| dst_dec_i | input | 1 | Destination pointer moves down |
| dst_byte_i | input | 1 | Destination is a byte access |
| valid_o | output | 1 | Results below belong to an operation |
| src_ea_o | output | DATA_W | Source effective address |
| src_mem_o | output | 1 | Source formed a memory address |
| dst_ea_o | output | DATA_W | Destination effective address |
| dst_mem_o | output | 1 | Destination formed a memory address |
| wb_src_en_o | output | 1 | Source pointer write-back performed |
| wb_src_sel_o | output | RSEL_W | Register written by the source write-back |
| wb_src_data_o | output | DATA_W | Source write-back value |
| wb_dst_en_o | output | 1 | Destination pointer write-back performed |
| wb_dst_sel_o | output | RSEL_W | Register written by the destination write-back |
| wb_dst_data_o | output | DATA_W | Destination write-back value |

## Verification
The bench keeps sixteen 16-bit registers but narrows the instruction field to 6 bits. This places the sign boundary of the literal offset (codes 0x1F, 0x20, 0x3F) among values that random stimulus hits often. It also makes the contrast between zero extension in file-register direct and sign extension in literal-offset mode easy to show. Random base selectors often coincide between source and destination, which brings the same-register collision of R11 into frequent reach. Directed loads of 0xFFFF and 0x0000 push pointer steps across the 16-bit wrap.

// File: rtl/eag_pkg.sv
package eag_pkg;

    // Addressing mode codes carried on src_mode_i / dst_mode_i
    typedef enum logic [2:0] {
        AM_FILE  = 3'd0,
        AM_REG   = 3'd1,
        AM_IND   = 3'd2,
        AM_POST  = 3'd3,
        AM_PRE   = 3'd4,
        AM_INDEX = 3'd5,
        AM_LIT   = 3'd6,
        AM_RSVD  = 3'd7
    } am_e;

endpackage

// File: rtl/eag_operand_calc.sv
module eag_operand_calc
    import eag_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 10
) (
    input  logic [2:0]         mode_i,
    input  logic [DATA_W-1:0]  base_i,
    input  logic [DATA_W-1:0]  index_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic               dec_i,
    input  logic               byte_i,
    output logic [DATA_W-1:0]  ea_o,
    output logic               mem_o,
    output logic               wb_en_o,
    output logic [DATA_W-1:0]  wb_data_o
);
    localparam int EXT_W = DATA_W - FIELD_W;

    am_e               mode;
    logic [DATA_W-1:0] step;
    logic [DATA_W-1:0] delta;
    logic [DATA_W-1:0] moved;
    logic [DATA_W-1:0] lit_sx;
    logic [DATA_W-1:0] fld_zx;

    always_comb begin
        mode   = am_e'(mode_i);
        step   = byte_i ? DATA_W'(1) : DATA_W'(2);
        delta  = dec_i ? (~step + DATA_W'(1)) : step;
        moved  = base_i + delta;
        lit_sx = {{EXT_W{field_i[FIELD_W-1]}}, field_i};
        fld_zx = {{EXT_W{1'b0}}, field_i};

        ea_o      = '0;
        mem_o     = 1'b1;
        wb_en_o   = 1'b0;
        wb_data_o = moved;

        case (mode)
            AM_FILE:  ea_o = fld_zx;
            AM_IND:   ea_o = base_i;
            AM_POST: begin
                ea_o    = base_i;
                wb_en_o = 1'b1;
            end
            AM_PRE: begin
                ea_o    = moved;
                wb_en_o = 1'b1;
            end
            AM_INDEX: ea_o = base_i + index_i;
            AM_LIT:   ea_o = base_i + lit_sx;
            default:  mem_o = 1'b0;   // register direct and unused code
        endcase
    end

endmodule

// File: rtl/eag_wb_arbiter.sv
module eag_wb_arbiter #(
    parameter int RSEL_W = 4
) (
    input  logic              op_valid_i,
    input  logic              src_req_i,
    input  logic [RSEL_W-1:0] src_sel_i,
    input  logic              dst_req_i,
    input  logic [RSEL_W-1:0] dst_sel_i,
    output logic              src_go_o,
    output logic              dst_go_o
);
    logic same_target;

    always_comb begin
        same_target = dst_req_i && (src_sel_i == dst_sel_i);
        dst_go_o    = op_valid_i && dst_req_i;
        src_go_o    = op_valid_i && src_req_i && !same_target;
    end

endmodule

// File: rtl/eag_regbank.sv
module eag_regbank #(
    parameter int NREG   = 16,
    parameter int DATA_W = 16,
    parameter int RSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RSEL_W-1:0] rd_a_sel_i,
    output logic [DATA_W-1:0] rd_a_o,
    input  logic [RSEL_W-1:0] rd_b_sel_i,
    output logic [DATA_W-1:0] rd_b_o,
    input  logic [RSEL_W-1:0] rd_c_sel_i,
    output logic [DATA_W-1:0] rd_c_o,
    input  logic              ext_en_i,
    input  logic [RSEL_W-1:0] ext_sel_i,
    input  logic [DATA_W-1:0] ext_data_i,
    input  logic              lo_en_i,
    input  logic [RSEL_W-1:0] lo_sel_i,
    input  logic [DATA_W-1:0] lo_data_i,
    input  logic              hi_en_i,
    input  logic [RSEL_W-1:0] hi_sel_i,
    input  logic [DATA_W-1:0] hi_data_i
);
    logic [DATA_W-1:0] bank_q [NREG];
    logic [DATA_W-1:0] bank_d [NREG];

    // Later writes override earlier ones: port, then low, then high priority.
    always_comb begin
        bank_d = bank_q;
        if (ext_en_i) bank_d[ext_sel_i] = ext_data_i;
        if (lo_en_i)  bank_d[lo_sel_i]  = lo_data_i;
        if (hi_en_i)  bank_d[hi_sel_i]  = hi_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_a_o = bank_q[rd_a_sel_i];
    assign rd_b_o = bank_q[rd_b_sel_i];
    assign rd_c_o = bank_q[rd_c_sel_i];

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
    import eag_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 10,
    localparam int RSEL_W = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [RSEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               op_valid_i,
    input  logic [RSEL_W-1:0]  idx_sel_i,
    input  logic [2:0]         src_mode_i,
    input  logic [RSEL_W-1:0]  src_sel_i,
    input  logic [FIELD_W-1:0] src_field_i,
    input  logic               src_dec_i,
    input  logic               src_byte_i,
    input  logic [2:0]         dst_mode_i,
    input  logic [RSEL_W-1:0]  dst_sel_i,
    input  logic [FIELD_W-1:0] dst_field_i,
    input  logic               dst_dec_i,
    input  logic               dst_byte_i,
    output logic               valid_o,
    output logic [DATA_W-1:0]  src_ea_o,
    output logic               src_mem_o,
    output logic [DATA_W-1:0]  dst_ea_o,
    output logic               dst_mem_o,
    output logic               wb_src_en_o,
    output logic [RSEL_W-1:0]  wb_src_sel_o,
    output logic [DATA_W-1:0]  wb_src_data_o,
    output logic               wb_dst_en_o,
    output logic [RSEL_W-1:0]  wb_dst_sel_o,
    output logic [DATA_W-1:0]  wb_dst_data_o
);
    localparam int NOPS = 2;   // index 0 = source, 1 = destination

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] src_ea;
        logic              src_mem;
        logic [DATA_W-1:0] dst_ea;
        logic              dst_mem;
        logic              swb_en;
        logic [RSEL_W-1:0] swb_sel;
        logic [DATA_W-1:0] swb_data;
        logic              dwb_en;
        logic [RSEL_W-1:0] dwb_sel;
        logic [DATA_W-1:0] dwb_data;
    } out_t;

    logic [2:0]         op_mode  [NOPS];
    logic [RSEL_W-1:0]  op_sel   [NOPS];
    logic [FIELD_W-1:0] op_field [NOPS];
    logic               op_dec   [NOPS];
    logic               op_byte  [NOPS];
    logic [DATA_W-1:0]  rd_base  [NOPS];
    logic [DATA_W-1:0]  rd_idx;
    logic [DATA_W-1:0]  calc_ea  [NOPS];
    logic               calc_mem [NOPS];
    logic               calc_wb  [NOPS];
    logic [DATA_W-1:0]  calc_wbd [NOPS];
    logic               src_go;
    logic               dst_go;
    out_t               out_d;
    out_t               out_q;

    always_comb begin
        op_mode[0]  = src_mode_i;
        op_sel[0]   = src_sel_i;
        op_field[0] = src_field_i;
        op_dec[0]   = src_dec_i;
        op_byte[0]  = src_byte_i;
        op_mode[1]  = dst_mode_i;
        op_sel[1]   = dst_sel_i;
        op_field[1] = dst_field_i;
        op_dec[1]   = dst_dec_i;
        op_byte[1]  = dst_byte_i;
    end

    eag_regbank #(
        .NREG   (NREG),
        .DATA_W (DATA_W),
        .RSEL_W (RSEL_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_sel_i (src_sel_i),
        .rd_a_o     (rd_base[0]),
        .rd_b_sel_i (dst_sel_i),
        .rd_b_o     (rd_base[1]),
        .rd_c_sel_i (idx_sel_i),
        .rd_c_o     (rd_idx),
        .ext_en_i   (wr_en_i),
        .ext_sel_i  (wr_sel_i),
        .ext_data_i (wr_data_i),
        .lo_en_i    (src_go),
        .lo_sel_i   (src_sel_i),
        .lo_data_i  (calc_wbd[0]),
        .hi_en_i    (dst_go),
        .hi_sel_i   (dst_sel_i),
        .hi_data_i  (calc_wbd[1])
    );

    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        eag_operand_calc #(
            .DATA_W  (DATA_W),
            .FIELD_W (FIELD_W)
        ) u_calc (
            .mode_i    (op_mode[g]),
            .base_i    (rd_base[g]),
            .index_i   (rd_idx),
            .field_i   (op_field[g]),
            .dec_i     (op_dec[g]),
            .byte_i    (op_byte[g]),
            .ea_o      (calc_ea[g]),
            .mem_o     (calc_mem[g]),
            .wb_en_o   (calc_wb[g]),
            .wb_data_o (calc_wbd[g])
        );
    end

    eag_wb_arbiter #(
        .RSEL_W (RSEL_W)
    ) u_arb (
        .op_valid_i (op_valid_i),
        .src_req_i  (calc_wb[0]),
        .src_sel_i  (src_sel_i),
        .dst_req_i  (calc_wb[1]),
        .dst_sel_i  (dst_sel_i),
        .src_go_o   (src_go),
        .dst_go_o   (dst_go)
    );

    always_comb begin
        out_d        = out_q;
        out_d.valid  = op_valid_i;
        out_d.swb_en = src_go;
        out_d.dwb_en = dst_go;
        if (op_valid_i) begin
            out_d.src_ea   = calc_ea[0];
            out_d.src_mem  = calc_mem[0];
            out_d.dst_ea   = calc_ea[1];
            out_d.dst_mem  = calc_mem[1];
            out_d.swb_sel  = src_sel_i;
            out_d.swb_data = calc_wbd[0];
            out_d.dwb_sel  = dst_sel_i;
            out_d.dwb_data = calc_wbd[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign valid_o       = out_q.valid;
    assign src_ea_o      = out_q.src_ea;
    assign src_mem_o     = out_q.src_mem;
    assign dst_ea_o      = out_q.dst_ea;
    assign dst_mem_o     = out_q.dst_mem;
    assign wb_src_en_o   = out_q.swb_en;
    assign wb_src_sel_o  = out_q.swb_sel;
    assign wb_src_data_o = out_q.swb_data;
    assign wb_dst_en_o   = out_q.dwb_en;
    assign wb_dst_sel_o  = out_q.dwb_sel;
    assign wb_dst_data_o = out_q.dwb_data;

endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 10,
    parameter int RSEL_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid_i,
    input logic [2:0]         src_mode_i,
    input logic [FIELD_W-1:0] src_field_i,
    input logic [DATA_W-1:0]  src_base,
    input logic [DATA_W-1:0]  idx_base,
    input logic               valid_o,
    input logic [DATA_W-1:0]  src_ea_o,
    input logic [DATA_W-1:0]  dst_ea_o,
    input logic               src_mem_o,
    input logic               wb_src_en_o,
    input logic [RSEL_W-1:0]  wb_src_sel_o,
    input logic               wb_dst_en_o,
    input logic [RSEL_W-1:0]  wb_dst_sel_o
);

    a_r13_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i |=> valid_o);

    a_r13_idle_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> (!valid_o && !wb_src_en_o && !wb_dst_en_o));

    a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> ($stable(src_ea_o) && $stable(dst_ea_o)));

    a_r11_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_src_en_o && wb_dst_en_o) |-> (wb_src_sel_o != wb_dst_sel_o));

    a_r3_direct_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (src_mode_i == 3'd1)) |=> (!src_mem_o && !wb_src_en_o));

    a_r2_file_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (src_mode_i == 3'd0)) |=>
            (src_ea_o == DATA_W'($past(src_field_i))) && src_mem_o);

    a_r4_indirect_base: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (src_mode_i == 3'd2)) |=> (src_ea_o == $past(src_base)));

    a_r7_indexed_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (src_mode_i == 3'd5)) |=>
            (src_ea_o == DATA_W'($past(src_base) + $past(idx_base))));

endmodule

bind eff_addr_unit eag_checker #(
    .DATA_W  (DATA_W),
    .FIELD_W (FIELD_W),
    .RSEL_W  (RSEL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid_i   (op_valid_i),
    .src_mode_i   (src_mode_i),
    .src_field_i  (src_field_i),
    .src_base     (rd_base[0]),
    .idx_base     (rd_idx),
    .valid_o      (valid_o),
    .src_ea_o     (src_ea_o),
    .dst_ea_o     (dst_ea_o),
    .src_mem_o    (src_mem_o),
    .wb_src_en_o  (wb_src_en_o),
    .wb_src_sel_o (wb_src_sel_o),
    .wb_dst_en_o  (wb_dst_en_o),
    .wb_dst_sel_o (wb_dst_sel_o)
);

// File: tb/eff_addr_unit_tb.sv
module eff_addr_unit_tb;
    localparam int FW = 6;

    typedef struct packed {
        logic          valid;
        logic          we;
        logic [3:0]    wsel;
        logic [15:0]   wdata;
        logic [3:0]    idx;
        logic [2:0]    sm;
        logic [3:0]    ss;
        logic [FW-1:0] sf;
        logic          sdec;
        logic          sbyt;
        logic [2:0]    dm;
        logic [3:0]    ds;
        logic [FW-1:0] df;
        logic          ddec;
        logic          dbyt;
    } op_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en_i, op_valid_i, src_dec_i, src_byte_i, dst_dec_i, dst_byte_i;
    logic [3:0] wr_sel_i, idx_sel_i, src_sel_i, dst_sel_i;
    logic [15:0] wr_data_i;
    logic [2:0] src_mode_i, dst_mode_i;
    logic [FW-1:0] src_field_i, dst_field_i;
    logic valid_o, src_mem_o, dst_mem_o, wb_src_en_o, wb_dst_en_o;
    logic [15:0] src_ea_o, dst_ea_o, wb_src_data_o, wb_dst_data_o;
    logic [3:0] wb_src_sel_o, wb_dst_sel_o;

    int n_tests = 0;
    int n_fail = 0;
    logic [15:0] mdl [16];
    logic [15:0] prev_sea = '0, prev_dea = '0;
    logic prev_smem = 1'b0, prev_dmem = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    eff_addr_unit #(.NREG(16), .DATA_W(16), .FIELD_W(FW)) u_dut (.*);

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected address behaviour per mode, taken from the requirements
    task automatic calc(input logic [2:0] mode, input logic [15:0] base, input logic [15:0] ix,
                        input logic [FW-1:0] fld, input logic dec, input logic byt,
                        output logic [15:0] ea, output logic mem, output logic wen, output logic [15:0] wd);
        logic [15:0] st;
        st = byt ? 16'd1 : 16'd2;
        if (dec) st = 16'd0 - st;
        ea = 16'h0; mem = 1'b1; wen = 1'b0; wd = 16'h0;
        case (mode)
            3'd0: ea = {{(16-FW){1'b0}}, fld};
            3'd2: ea = base;
            3'd3: begin ea = base; wen = 1'b1; wd = base + st; end
            3'd4: begin ea = base + st; wen = 1'b1; wd = base + st; end
            3'd5: ea = base + ix;
            3'd6: ea = base + {{(16-FW){fld[FW-1]}}, fld};
            default: mem = 1'b0;
        endcase
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic do_op(input string tag, input op_t o);
        logic [15:0] sea, dea, swd, dwd;
        logic smem, dmem, swen, dwen, sgo, dgo;
        wr_en_i = o.we; wr_sel_i = o.wsel; wr_data_i = o.wdata;
        op_valid_i = o.valid; idx_sel_i = o.idx;
        src_mode_i = o.sm; src_sel_i = o.ss; src_field_i = o.sf; src_dec_i = o.sdec; src_byte_i = o.sbyt;
        dst_mode_i = o.dm; dst_sel_i = o.ds; dst_field_i = o.df; dst_dec_i = o.ddec; dst_byte_i = o.dbyt;
        calc(o.sm, mdl[o.ss], mdl[o.idx], o.sf, o.sdec, o.sbyt, sea, smem, swen, swd);
        calc(o.dm, mdl[o.ds], mdl[o.idx], o.df, o.ddec, o.dbyt, dea, dmem, dwen, dwd);
        dgo = o.valid && dwen;
        sgo = o.valid && swen && !(dwen && (o.ss == o.ds));
        if (!o.valid) begin
            sea = prev_sea; dea = prev_dea; smem = prev_smem; dmem = prev_dmem;
        end
        if (o.we) mdl[o.wsel] = o.wdata;
        if (sgo)  mdl[o.ss] = swd;
        if (dgo)  mdl[o.ds] = dwd;
        prev_sea = sea; prev_dea = dea; prev_smem = smem; prev_dmem = dmem;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "valid_o", 16'(valid_o), 16'(o.valid));
        chk(tag, "src_ea", src_ea_o, sea);
        chk(tag, "dst_ea", dst_ea_o, dea);
        chk(tag, "src_mem", 16'(src_mem_o), 16'(smem));
        chk(tag, "dst_mem", 16'(dst_mem_o), 16'(dmem));
        chk(tag, "src_wb_en", 16'(wb_src_en_o), 16'(sgo));
        chk(tag, "dst_wb_en", 16'(wb_dst_en_o), 16'(dgo));
        if (sgo) begin
            chk(tag, "src_wb_sel", 16'(wb_src_sel_o), 16'(o.ss));
            chk(tag, "src_wb_data", wb_src_data_o, swd);
        end
        if (dgo) begin
            chk(tag, "dst_wb_sel", 16'(wb_dst_sel_o), 16'(o.ds));
            chk(tag, "dst_wb_data", wb_dst_data_o, dwd);
        end
    endtask

    task automatic load(input logic [3:0] r, input logic [15:0] v);
        op_t o;
        o = '0; o.we = 1'b1; o.wsel = r; o.wdata = v;
        do_op("R13", o);
    endtask

    task automatic peek(input string tag, input logic [3:0] r);
        op_t o;
        o = '0; o.valid = 1'b1; o.sm = 3'd2; o.ss = r; o.dm = 3'd1;
        do_op(tag, o);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        op_t o;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        wr_en_i = 0; op_valid_i = 0; wr_sel_i = 0; wr_data_i = 0; idx_sel_i = 0;
        src_mode_i = 0; src_sel_i = 0; src_field_i = 0; src_dec_i = 0; src_byte_i = 0;
        dst_mode_i = 0; dst_sel_i = 0; dst_field_i = 0; dst_dec_i = 0; dst_byte_i = 0;
        repeat (3) @(negedge clk);
        chk("R1", "valid_o", 16'(valid_o), 16'h0);
        chk("R1", "src_ea", src_ea_o, 16'h0);
        chk("R1", "dst_ea", dst_ea_o, 16'h0);
        chk("R1", "wb_en", 16'({wb_src_en_o, wb_dst_en_o}), 16'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            o = '0; o.valid = 1; o.sm = 3'd2; o.ss = 4'(i); o.dm = 3'd2; o.ds = 4'(15 - i);
            do_op("R1", o);
        end
        // R2: zero extension of the field, even with its top bit set
        o = '0; o.valid = 1; o.sm = 3'd0; o.sf = 6'h2A; o.dm = 3'd0; o.df = 6'h3F;
        do_op("R2", o);
        // R3: register direct and code 7 leave the register alone
        load(4'd4, 16'h1234);
        o = '0; o.valid = 1; o.sm = 3'd1; o.ss = 4'd4; o.dm = 3'd7; o.ds = 4'd4;
        do_op("R3", o);
        peek("R3", 4'd4);
        // R9: wrap on post-increment and pre-decrement
        load(4'd1, 16'hFFFF);
        load(4'd2, 16'h0000);
        o = '0; o.valid = 1; o.sm = 3'd3; o.ss = 4'd1; o.dm = 3'd4; o.ds = 4'd2; o.ddec = 1; o.dbyt = 1;
        do_op("R9", o);
        peek("R9", 4'd1);
        // R8: sign boundary of the literal
        load(4'd3, 16'h0010);
        o = '0; o.valid = 1; o.sm = 3'd6; o.ss = 4'd3; o.sf = 6'h3F; o.dm = 3'd6; o.ds = 4'd3; o.df = 6'h1F;
        do_op("R8", o);
        o.sf = 6'h20; o.df = 6'h01;
        do_op("R8", o);
        // R7: one shared index register for both operands
        load(4'd6, 16'h0100); load(4'd5, 16'h2000); load(4'd7, 16'h0005);
        o = '0; o.valid = 1; o.idx = 4'd7; o.sm = 3'd5; o.ss = 4'd6; o.dm = 3'd5; o.ds = 4'd5;
        do_op("R7", o);
        // R10: both operands see pre-operation values
        load(4'd10, 16'h0040);
        o = '0; o.valid = 1; o.sm = 3'd3; o.ss = 4'd10; o.dm = 3'd2; o.ds = 4'd10;
        do_op("R10", o);
        peek("R10", 4'd10);
        // R11: destination wins on a shared pointer
        load(4'd8, 16'h0080);
        o = '0; o.valid = 1; o.sm = 3'd3; o.ss = 4'd8; o.dm = 3'd4; o.ds = 4'd8; o.ddec = 1; o.dbyt = 1;
        do_op("R11", o);
        peek("R11", 4'd8);
        // R12: pointer update beats the write port; independent write lands
        load(4'd9, 16'h0300);
        o = '0; o.valid = 1; o.we = 1; o.wsel = 4'd9; o.wdata = 16'hBEEF; o.sm = 3'd1; o.dm = 3'd3; o.ds = 4'd9;
        do_op("R12", o);
        peek("R12", 4'd9);
        o = '0; o.valid = 1; o.we = 1; o.wsel = 4'd11; o.wdata = 16'hA5A5; o.sm = 3'd4; o.ss = 4'd12;
        do_op("R12", o);
        peek("R12", 4'd11);
        // R13: idle cycle holds addresses
        o = '0;
        do_op("R13", o);
        // random mix
        for (int n = 0; n < 1500; n++) begin
            o.valid = ($urandom % 8) != 0;
            o.we    = ($urandom % 4) == 0;
            o.wsel  = 4'($urandom);
            o.wdata = 16'($urandom);
            o.idx   = 4'($urandom);
            o.sm    = 3'($urandom);
            o.ss    = 4'($urandom);
            o.sf    = FW'($urandom);
            o.sdec  = 1'($urandom);
            o.sbyt  = 1'($urandom);
            o.dm    = 3'($urandom);
            o.ds    = (($urandom % 3) == 0) ? o.ss : 4'($urandom);
            o.df    = FW'($urandom);
            o.ddec  = 1'($urandom);
            o.dbyt  = 1'($urandom);
            do_op(o.valid ? mode_tag(o.sm) : "R13", o);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule